// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block sets the timing of the SCL clock for an I2C master. A 19-bit configuration word holds two 8-bit dividers, one for the low phase and one for the high phase, and a 3-bit exponent that both dividers share. Each phase lasts `divider * 2^exponent + 2` system clocks. A low phase and a high phase with equal dividers therefore give a full SCL period of `2*d*2^e + 4` clocks.

Software derives the divider as `ceil(Fclk / (2*Fscl)) - 2`. It then picks the smallest exponent that lets the divider fit in 8 bits. The usual target is a 100 kHz SCL, and the block is meant for rates up to 400 kHz.

The block drives a pull-low request for SCL. It marks the first cycle of each low phase with a fall tick and the first cycle of each high phase with a rise tick, and the master's bit FSM uses these ticks to place data changes and samples. The high phase counts only while SCL reads high, so a slave that holds SCL low stretches the clock. A new configuration is taken only when a low phase begins. An elaboration option caps the exponent at 5.

Top module: `scl_wavegen`

## Requirements
- R1: The configuration word is split as follows: bits [7:0] are the low divider, bits [15:8] are the high divider, and bits [18:16] are the exponent.
- R2: Every low phase drives `scl_pull_low` high for exactly `lo_div * 2^e + 2` consecutive cycles. This includes divider 0, which gives 2 cycles.
- R3: When SCL is not stretched, every high phase keeps `scl_pull_low` low for exactly `hi_div * 2^e + 2` cycles.
- R4: When the low and high dividers are equal (d), one full SCL period lasts `2*d*2^e + 4` cycles.
- R5: With `CLAMP_EXP` = 0, all exponent values 0 to 7 apply as written. With `CLAMP_EXP` = 1, exponents 6 and 7 act as 5, and exponents 5 and below are unchanged.
- R6: The high-phase count advances only on cycles where `scl_in` is 1. Each cycle that `scl_in` is held low during a high phase lengthens that phase by one cycle, and `stretching` reads 1 on those cycles.
- R7: The configuration is latched when a low phase starts. Changing `cfg_word` during a low phase changes neither that low phase nor the high phase after it. The new value applies from the next low phase.
- R8: When `en` is 0, `scl_pull_low`, `fall_tick` and `rise_tick` are 0 from the next cycle on, and the counters are cleared. After `en` returns to 1, a full-length low phase starts on the next cycle.
- R9: `fall_tick` is a one-cycle pulse in the first cycle of each low phase. `rise_tick` is a one-cycle pulse in the first cycle of each high phase.
- R10: During and after reset, `scl_pull_low`, `fall_tick` and `rise_tick` are 0 until the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable for the generator; 0 releases SCL and clears the counters |
| cfg_word | input | 19 | Low divider [7:0], high divider [15:8], exponent [18:16] |
| scl_in | input | 1 | Sampled SCL line level, already synchronised |
| scl_pull_low | output | 1 | 1 requests that SCL be driven low |
| fall_tick | output | 1 | Pulse in the first cycle of a low phase |
| rise_tick | output | 1 | Pulse in the first cycle of a high phase |
| stretching | output | 1 | High phase is stalled because SCL reads low |

## Verification
A wrong counter value shows at the ports as a wrong phase length, measured in cycles between `fall_tick` and `rise_tick`, and shows up no later than the end of the phase in progress. A wrong phase state shows within one cycle: `scl_pull_low` disagrees with the tick that was just issued. A stale or early configuration latch shows one phase late, as a high phase that uses the wrong divider. The scoreboard measures every phase length and compares it with a value computed from R2, R3, R5 and R6. A second instance, built with the exponent clamp, measures the capped lengths.

// File: rtl/scl_wavegen.sv
module scl_wavegen #(
  parameter int DIV_W     = 8,
  parameter int EXP_W     = 3,
  parameter bit CLAMP_EXP = 1'b0,
  parameter int EXP_CAP   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [2*DIV_W+EXP_W-1:0]   cfg_word,
  input  logic                       scl_in,
  output logic                       scl_pull_low,
  output logic                       fall_tick,
  output logic                       rise_tick,
  output logic                       stretching
);
  localparam int CFG_W = 2*DIV_W + EXP_W;
  localparam int CNT_W = DIV_W + (1 << EXP_W) + 1;

  typedef enum logic [1:0] {S_OFF, S_LOW, S_HIGH} phase_t;

  phase_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [DIV_W-1:0]   hi_div_q;
  logic [EXP_W-1:0]   exp_q;
  logic               fall_q, rise_q;

  wire [DIV_W-1:0] lo_div_in = cfg_word[DIV_W-1:0];
  wire [DIV_W-1:0] hi_div_in = cfg_word[2*DIV_W-1:DIV_W];
  wire [EXP_W-1:0] exp_in    = cfg_word[CFG_W-1:2*DIV_W];

  function automatic logic [EXP_W-1:0] eff_exp(input logic [EXP_W-1:0] e);
    if (CLAMP_EXP && int'(e) > EXP_CAP) return EXP_W'(EXP_CAP);
    return e;
  endfunction

  // counter load = phase length - 1 = div * 2^e + 1
  function automatic logic [CNT_W-1:0] load_of(input logic [DIV_W-1:0] d,
                                               input logic [EXP_W-1:0] e);
    return (CNT_W'(d) << eff_exp(e)) + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      cnt      <= '0;
      hi_div_q <= '0;
      exp_q    <= '0;
      fall_q   <= 1'b0;
      rise_q   <= 1'b0;
    end else if (!en) begin
      state  <= S_OFF;
      cnt    <= '0;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      unique case (state)
        S_OFF, S_HIGH: begin
          if (state == S_OFF || (scl_in && cnt == '0)) begin
            state    <= S_LOW;
            cnt      <= load_of(lo_div_in, exp_in);
            hi_div_q <= hi_div_in;
            exp_q    <= exp_in;
            fall_q   <= 1'b1;
          end else if (scl_in) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_LOW: begin
          if (cnt == '0) begin
            state  <= S_HIGH;
            cnt    <= load_of(hi_div_q, exp_q);
            rise_q <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end

  assign scl_pull_low = (state == S_LOW);
  assign fall_tick    = fall_q;
  assign rise_tick    = rise_q;
  assign stretching   = (state == S_HIGH) && !scl_in;

  // R8
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull_low && !fall_tick && !rise_tick));

  // R9
  fall_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> scl_pull_low);

  // R9
  rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (!scl_pull_low && $past(scl_pull_low)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && !scl_in && en) |=> (state == S_HIGH && cnt == $past(cnt)));

  // R2
  low_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOW && cnt != '0 && en) |=> (scl_pull_low && cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: tb/scl_wavegen_tb.sv
module scl_wavegen_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, en, hold;
  logic [18:0] cfg;
  logic        oe, fall_tick, rise_tick, stretching;
  logic        c_oe, c_fall, c_rise, c_str;
  wire         scl_in = ~oe & ~hold;
  wire         c_scl  = ~c_oe;

  scl_wavegen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg), .scl_in(scl_in),
    .scl_pull_low(oe), .fall_tick(fall_tick), .rise_tick(rise_tick), .stretching(stretching));

  scl_wavegen #(.CLAMP_EXP(1'b1)) u_clamp (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg), .scl_in(c_scl),
    .scl_pull_low(c_oe), .fall_tick(c_fall), .rise_tick(c_rise), .stretching(c_str));

  typedef struct { bit is_high; int len; string tag; } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;
  int lo_run = 0, hi_run = 0;
  bit have_lo = 0, have_hi = 0;

  function automatic int plen(int d, int e, bit clamp);
    int ee = (clamp && e > 5) ? 5 : e;
    return d * (1 << ee) + 2;
  endfunction

  function automatic logic [18:0] mk(int lo, int hi, int e);
    return {3'(e), 8'(hi), 8'(lo)};
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(bit h, int len, string tag);
    exp_t e;
    e.is_high = h; e.len = len; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic pop_cmp(bit h, int run);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R2/R3", "unexpected phase length", run, 0);
    end else begin
      e = q.pop_front();
      chk(e.is_high == h, e.tag, "phase kind", int'(h), int'(e.is_high));
      chk(e.len == run, e.tag, h ? "high phase cycles" : "low phase cycles", run, e.len);
    end
  endtask

  always @(negedge clk) begin
    if (!en) begin
      have_lo = 0; have_hi = 0;
    end else if (fall_tick) begin
      if (have_hi) pop_cmp(1'b1, hi_run);
      lo_run = 1; have_lo = 1; have_hi = 0;
    end else if (rise_tick) begin
      if (have_lo) pop_cmp(1'b0, lo_run);
      hi_run = 1; have_hi = 1; have_lo = 0;
    end else if (oe) begin
      lo_run++;
    end else if (have_hi) begin
      hi_run++;
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic measure_clamp(int exp_lo, int exp_hi);
    int n = 0, m = 0;
    while (!c_fall) @(negedge clk);
    do begin @(negedge clk); n++; end while (c_oe);
    do begin @(negedge clk); m++; end while (!c_fall);
    chk(n == exp_lo, "R5", "clamped low cycles", n, exp_lo);
    chk(m == exp_hi, "R5", "clamped high cycles", m, exp_hi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; hold = 1'b0; cfg = '0;
    repeat (3) @(negedge clk);
    chk(!oe && !fall_tick && !rise_tick, "R10", "outputs in reset", int'(oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!oe && !fall_tick, "R10", "idle after reset", int'(oe), 0);

    // R2 R3 R4 R9: equal dividers, exponent 0
    cfg = mk(3, 3, 0);
    push(0, 5, "R2"); push(1, 5, "R3"); push(0, 5, "R4"); push(1, 5, "R4");
    en = 1'b1;
    @(negedge clk);
    chk(fall_tick && oe, "R9", "fall tick at low start", int'(fall_tick), 1);
    @(negedge clk);
    chk(!fall_tick, "R9", "fall tick one cycle", int'(fall_tick), 0);
    drain();

    // R1: distinct fields
    cfg = mk(1, 6, 2);
    push(0, plen(1, 2, 0), "R1"); push(1, plen(6, 2, 0), "R1");
    en = 1'b1; drain();
    cfg = mk(5, 2, 1);
    push(0, plen(5, 1, 0), "R1"); push(1, plen(2, 1, 0), "R1");
    en = 1'b1; drain();

    // R2: zero dividers
    cfg = mk(0, 0, 0);
    push(0, 2, "R2"); push(1, 2, "R3"); push(0, 2, "R2"); push(1, 2, "R3");
    en = 1'b1; drain();

    // R5: exponent 7, unclamped and clamped
    cfg = mk(2, 1, 7);
    push(0, plen(2, 7, 0), "R5"); push(1, plen(1, 7, 0), "R5");
    en = 1'b1;
    measure_clamp(plen(2, 7, 1), plen(1, 7, 1));
    drain();
    // R5: exponent 5 left alone by clamp
    cfg = mk(1, 1, 5);
    push(0, plen(1, 5, 0), "R5"); push(1, plen(1, 5, 0), "R5");
    en = 1'b1;
    measure_clamp(plen(1, 5, 1), plen(1, 5, 1));
    drain();

    // R6: stretch 7 cycles
    cfg = mk(2, 2, 1);
    push(0, 6, "R6"); push(1, 6 + 7, "R6");
    en = 1'b1;
    do @(negedge clk); while (!rise_tick);
    hold = 1'b1;
    repeat (3) @(negedge clk);
    chk(stretching && !oe, "R6", "stretching flag", int'(stretching), 1);
    repeat (4) @(negedge clk);
    hold = 1'b0;
    drain();

    // R7: change mid-low
    cfg = mk(4, 4, 0);
    push(0, 6, "R7"); push(1, 6, "R7"); push(0, plen(1, 1, 0), "R7"); push(1, plen(9, 1, 0), "R7");
    en = 1'b1;
    repeat (3) @(negedge clk);
    cfg = mk(1, 9, 1);
    drain();

    // R8: disable mid-low then re-enable
    cfg = mk(50, 50, 0);
    en = 1'b1;
    repeat (10) @(negedge clk);
    chk(oe, "R8", "low before disable", int'(oe), 1);
    en = 1'b0;
    @(negedge clk);
    chk(!oe && !fall_tick && !rise_tick, "R8", "released after disable", int'(oe), 0);
    repeat (2) @(negedge clk);
    push(0, 52, "R8"); push(1, 52, "R8");
    en = 1'b1;
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule